// File: doc/BRIEF.md
# Banked Narrow-Host Dword Access Port

This block lets a host with an 8-bit or 16-bit data bus reach a space of 32-bit internal registers. It holds three separate index/data pairs. Software picks a register by writing its number into a bank's index register, then moves the dword through that bank's data register in two word cycles or four byte cycles. Each bank, and a direct FIFO data port beside them, owns a private assembler. Narrow cycles aimed at different banks may therefore be mixed in any order without damaging a half-built access on another bank.

Writes reach the internal register in one 32-bit strobe, raised in the same cycle as the final part. Reads fetch all 32 bits on the first part. Later parts come from a holding latch, so a register that changes in the middle of a read cannot tear the value. Lane order is little endian and fixed. Each assembler is a three-state machine: `PK_IDLE` (no access open), `PK_WRITE` (write parts gathered) and `PK_READ` (read value latched). The transitions are:

- `begin_new`, from any state into `PK_WRITE` or `PK_READ`: an offset-0 cycle that does not continue the access already open.
- `seq_ok`, which stays in the current state: the expected next offset, in the open direction.
- Completion, back to `PK_IDLE`: the last part.
- Drop, back to `PK_IDLE`: any other cycle.
- Restart, back to `PK_IDLE`: a write to the bank's index.

Top module: `hba_indexed_port`

## Requirements
- R1: Host byte address bits [4:2] select a region: 0/2/4 index of bank 0/1/2, 1/3/5 data of bank 0/1/2, 6 FIFO data, 7 unused. A write at offset 0 of an index region loads the low IDX_W bits of the write data. A read at offset 0 of an index region returns the index zero-extended. A read at any other offset of an index region returns 0.
- R2: With `hb_wide`=1, a data dword is written as word offsets 0 then 2. `reg_wr` pulses once, during the second cycle, with `reg_addr` equal to the bank index and `reg_wdata` = {second word, first word}. The first cycle raises no strobe.
- R3: With `hb_wide`=0, a data dword is written as bytes at offsets 0,1,2,3. Byte n lands in bits [8n+7:8n], and `reg_wr` pulses only during the fourth byte.
- R4: The first read part (offset 0) pulses `reg_rd` once, with `reg_addr` equal to the bank index, and returns lane 0. The remaining parts return lanes of the value captured at that fetch and issue no further `reg_rd`, even if the register has changed since. In 8-bit mode the byte sits in bits [7:0] and bits [15:8] read 0.
- R5: Each bank keeps its own partial-access progress. Parts sent to different banks in any interleaving produce the same dwords as sequential access, and no two internal strobes occur in one cycle.
- R6: Writing a bank's index discards that bank's open partial access. A following non-zero-offset part on that bank causes no internal access.
- R7: A part whose offset or direction is not the expected next one drops the open access without any internal strobe. An offset-0 part always begins a new access.
- R8: The FIFO region packs exactly like a bank. A completed write pulses `fifo_push` with the dword, and the first read part pulses `fifo_pop` and captures `fifo_rdata`. The FIFO region never raises `reg_wr` or `reg_rd`.
- R9: `hb_rdata` is registered. It shows the read result from the clock edge that ends the read cycle, holds its value through cycles without a read, and is 0 after reset.
- R10: Cycles to the unused region raise no internal strobe and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hb_wide | input | 1 | 1 = 16-bit host cycles, 0 = 8-bit |
| hb_wr | input | 1 | Host write strobe, one cycle |
| hb_rd | input | 1 | Host read strobe, one cycle |
| hb_addr | input | 5 | Host byte address |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, registered |
| reg_wr | output | 1 | Internal dword write strobe |
| reg_rd | output | 1 | Internal dword read strobe |
| reg_addr | output | IDX_W | Internal register number |
| reg_wdata | output | 32 | Internal write dword |
| reg_rdata | input | 32 | Internal read dword, valid in the strobe cycle |
| fifo_push | output | 1 | FIFO dword push strobe |
| fifo_wdata | output | 32 | FIFO push dword |
| fifo_pop | output | 1 | FIFO dword pop strobe |
| fifo_rdata | input | 32 | FIFO head dword |

## Verification
A wrong count or state inside one assembler shows up at the ports on the very cycle of the next part to that bank. The symptom is either a `reg_wr` at the wrong part, a missing `reg_wr`, or a dword with its lanes shuffled. A corrupted holding latch appears in `hb_rdata` one edge after the second read part. A bank that leaks progress into another bank only shows when parts are interleaved, which is why the random stimulus round-robins parts across all three banks and reads every dword back through the same interleaving.

// File: rtl/hba_pkg.sv
`timescale 1ns/1ps
package hba_pkg;

    localparam int NBANK   = 3;
    localparam int ADDR_W  = 5;
    localparam int HWORD_W = 16;
    localparam int DWORD_W = 32;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_WRITE = 2'd1,
        PK_READ  = 2'd2
    } pk_state_e;

    localparam logic [2:0] RG_FIFO = 3'd6;

    // Extract the lane addressed by a byte offset (little endian).
    function automatic logic [15:0] get_lane(logic [31:0] dw, logic [1:0] offs, logic wide);
        if (wide)
            return dw[{offs[1], 4'd0} +: 16];
        else
            return {8'h00, dw[{offs, 3'd0} +: 8]};
    endfunction

    // Replace the lane addressed by a byte offset.
    function automatic logic [31:0] put_lane(logic [31:0] dw, logic [1:0] offs, logic wide,
                                             logic [15:0] lane);
        logic [31:0] r;
        r = dw;
        if (wide)
            r[{offs[1], 4'd0} +: 16] = lane;
        else
            r[{offs, 3'd0} +: 8] = lane[7:0];
        return r;
    endfunction

endpackage

// File: rtl/hba_decode.sv
`timescale 1ns/1ps
module hba_decode
    import hba_pkg::*;
(
    input  logic [2:0]       region,
    output logic [NBANK-1:0] idx_sel,
    output logic [NBANK-1:0] dat_sel,
    output logic             fifo_sel
);

    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        localparam logic [2:0] RG_IDX = 3'(2 * b);
        localparam logic [2:0] RG_DAT = 3'(2 * b + 1);
        assign idx_sel[b] = (region == RG_IDX);
        assign dat_sel[b] = (region == RG_DAT);
    end

    assign fifo_sel = (region == RG_FIFO);

endmodule

// File: rtl/hba_packer.sv
`timescale 1ns/1ps
module hba_packer
    import hba_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide,
    input  logic        hit_wr,
    input  logic        hit_rd,
    input  logic        restart,
    input  logic [1:0]  offs,
    input  logic [15:0] wdata,
    input  logic [31:0] fetch_data,
    output logic        commit,
    output logic [31:0] commit_data,
    output logic        fetch,
    output logic [15:0] rd_lane
);

    pk_state_e   state, state_d;
    logic [1:0]  cnt, cnt_d;
    logic [31:0] asm_q;
    logic [31:0] hold_q;

    logic [1:0]  exp_off;
    logic        last;
    logic        aligned;
    logic        hit;
    logic        dir_ok;
    logic        seq_ok;
    logic        begin_new;

    assign hit     = hit_wr | hit_rd;
    assign exp_off = wide ? {cnt[0], 1'b0} : cnt;
    assign last    = wide ? (cnt == 2'd1) : (cnt == 2'd3);
    assign aligned = !wide || !offs[0];

    // Direction that continues the open access.
    always_comb begin
        unique case (state)
            PK_IDLE:  dir_ok = 1'b0;
            PK_WRITE: dir_ok = hit_wr;
            PK_READ:  dir_ok = hit_rd;
            default:  dir_ok = 1'b0;
        endcase
    end

    assign seq_ok    = dir_ok && aligned && (offs == exp_off);
    assign begin_new = hit && (offs == 2'd0) && !seq_ok;

    // Next-state logic.
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        if (restart) begin
            state_d = PK_IDLE;
            cnt_d   = 2'd0;
        end else if (hit) begin
            if (seq_ok) begin
                if (last) begin
                    state_d = PK_IDLE;
                    cnt_d   = 2'd0;
                end else begin
                    cnt_d = cnt + 2'd1;
                end
            end else if (begin_new) begin
                state_d = hit_wr ? PK_WRITE : PK_READ;
                cnt_d   = 2'd1;
            end else begin
                state_d = PK_IDLE;
                cnt_d   = 2'd0;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PK_IDLE;
            cnt   <= 2'd0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        commit      = hit_wr && seq_ok && last;
        commit_data = put_lane(asm_q, offs, wide, wdata);
        fetch       = hit_rd && begin_new;
        if (fetch)
            rd_lane = get_lane(fetch_data, 2'd0, wide);
        else if (hit_rd && seq_ok)
            rd_lane = get_lane(hold_q, offs, wide);
        else
            rd_lane = 16'h0000;
    end

    // Assembly buffer and read holding latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q  <= '0;
            hold_q <= '0;
        end else begin
            if (hit_wr && begin_new)
                asm_q <= put_lane('0, 2'd0, wide, wdata);
            else if (hit_wr && seq_ok && !last)
                asm_q <= commit_data;
            if (fetch)
                hold_q <= fetch_data;
        end
    end

    AST_COMMIT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (state == PK_WRITE)); // R2
    AST_FETCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> (offs == 2'd0)); // R4
    AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == PK_IDLE)); // R6
    AST_STRAY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !seq_ok && offs != 2'd0) |=> (state == PK_IDLE && !commit)); // R7

endmodule

// File: rtl/hba_bank.sv
`timescale 1ns/1ps
module hba_bank
    import hba_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [1:0]       offs,
    input  logic [15:0]      wdata,
    input  logic [31:0]      fetch_data,
    output logic [IDX_W-1:0] idx,
    output logic             commit,
    output logic [31:0]      commit_data,
    output logic             fetch,
    output logic [15:0]      rd_lane
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (idx_wr)
            idx <= idx_wdata;
    end

    hba_packer u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide        (wide),
        .hit_wr      (dat_wr),
        .hit_rd      (dat_rd),
        .restart     (idx_wr),
        .offs        (offs),
        .wdata       (wdata),
        .fetch_data  (fetch_data),
        .commit      (commit),
        .commit_data (commit_data),
        .fetch       (fetch),
        .rd_lane     (rd_lane)
    );

endmodule

// File: rtl/hba_indexed_port.sv
`timescale 1ns/1ps
module hba_indexed_port
    import hba_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_wide,
    input  logic             hb_wr,
    input  logic             hb_rd,
    input  logic [4:0]       hb_addr,
    input  logic [15:0]      hb_wdata,
    output logic [15:0]      hb_rdata,
    output logic             reg_wr,
    output logic             reg_rd,
    output logic [IDX_W-1:0] reg_addr,
    output logic [31:0]      reg_wdata,
    input  logic [31:0]      reg_rdata,
    output logic             fifo_push,
    output logic [31:0]      fifo_wdata,
    output logic             fifo_pop,
    input  logic [31:0]      fifo_rdata
);

    logic [1:0]       offs;
    logic [NBANK-1:0] idx_sel, dat_sel;
    logic             fifo_sel;

    logic [IDX_W-1:0] idx_q      [NBANK];
    logic [NBANK-1:0] b_commit, b_fetch;
    logic [31:0]      b_cdata    [NBANK];
    logic [15:0]      b_lane     [NBANK];
    logic [15:0]      i_lane     [NBANK];
    logic [15:0]      f_lane;
    logic [15:0]      rdata_d;

    assign offs = hb_addr[1:0];

    hba_decode u_decode (
        .region   (hb_addr[4:2]),
        .idx_sel  (idx_sel),
        .dat_sel  (dat_sel),
        .fifo_sel (fifo_sel)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        hba_bank #(.IDX_W(IDX_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wide        (hb_wide),
            .idx_wr      (hb_wr && idx_sel[b] && offs == 2'd0),
            .idx_wdata   (hb_wdata[IDX_W-1:0]),
            .dat_wr      (hb_wr && dat_sel[b]),
            .dat_rd      (hb_rd && dat_sel[b]),
            .offs        (offs),
            .wdata       (hb_wdata),
            .fetch_data  (reg_rdata),
            .idx         (idx_q[b]),
            .commit      (b_commit[b]),
            .commit_data (b_cdata[b]),
            .fetch       (b_fetch[b]),
            .rd_lane     (b_lane[b])
        );
        assign i_lane[b] = (hb_rd && idx_sel[b] && offs == 2'd0) ? 16'(idx_q[b]) : 16'h0000;
    end

    hba_packer u_fifo_pk (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide        (hb_wide),
        .hit_wr      (hb_wr && fifo_sel),
        .hit_rd      (hb_rd && fifo_sel),
        .restart     (1'b0),
        .offs        (offs),
        .wdata       (hb_wdata),
        .fetch_data  (fifo_rdata),
        .commit      (fifo_push),
        .commit_data (fifo_wdata),
        .fetch       (fifo_pop),
        .rd_lane     (f_lane)
    );

    // Internal port: only the addressed bank can strobe in a cycle.
    always_comb begin
        reg_addr  = '0;
        reg_wdata = '0;
        rdata_d   = f_lane;
        for (int b = 0; b < NBANK; b++) begin
            if (idx_sel[b] || dat_sel[b])
                reg_addr = reg_addr | idx_q[b];
            if (b_commit[b])
                reg_wdata = reg_wdata | b_cdata[b];
            rdata_d = rdata_d | b_lane[b] | i_lane[b];
        end
    end

    assign reg_wr = |b_commit;
    assign reg_rd = |b_fetch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hb_rdata <= '0;
        else if (hb_rd)
            hb_rdata <= rdata_d;
    end

    AST_ONE_INT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_wr, reg_rd, fifo_push, fifo_pop}) <= 1); // R5
    AST_INT_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd || fifo_push || fifo_pop) |-> (hb_wr || hb_rd)); // R10
    AST_FIFO_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_sel |-> !(reg_wr || reg_rd)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_rd |=> $stable(hb_rdata)); // R9

endmodule

// File: tb/hba_indexed_port_bench.sv
`timescale 1ns/1ps
module hba_indexed_port_bench;

    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hb_wide = 1'b1;
    logic             hb_wr = 1'b0;
    logic             hb_rd = 1'b0;
    logic [4:0]       hb_addr = '0;
    logic [15:0]      hb_wdata = '0;
    logic [15:0]      hb_rdata;
    logic             reg_wr, reg_rd, fifo_push, fifo_pop;
    logic [IDX_W-1:0] reg_addr;
    logic [31:0]      reg_wdata, reg_rdata, fifo_wdata;
    logic [31:0]      fifo_src = '0;

    logic [31:0] mem [0:255];
    int          wr_cnt = 0, rd_cnt = 0, push_cnt = 0, pop_cnt = 0;
    logic [31:0] last_push = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    hba_indexed_port #(.IDX_W(IDX_W)) u_hba_indexed_port (
        .clk(clk), .rst_n(rst_n), .hb_wide(hb_wide), .hb_wr(hb_wr), .hb_rd(hb_rd),
        .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_src)
    );

    assign reg_rdata = mem[reg_addr];

    // Register-file and FIFO model observed at the ports.
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd)    rd_cnt <= rd_cnt + 1;
        if (fifo_push) begin
            push_cnt  <= push_cnt + 1;
            last_push <= fifo_wdata;
        end
        if (fifo_pop)  pop_cnt <= pop_cnt + 1;
    end

    function automatic logic [15:0] lane(logic [31:0] v, int p, bit wide);
        return wide ? v[16*p +: 16] : {8'h00, v[8*p +: 8]};
    endfunction

    function automatic int nparts(bit wide);
        return wide ? 2 : 4;
    endfunction

    function automatic logic [1:0] poff(int p, bit wide);
        return wide ? 2'(2 * p) : 2'(p);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc_wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
        @(negedge clk);
        hb_wr = 1'b0;
    endtask

    task automatic cyc_rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        hb_addr = a; hb_rd = 1'b1;
        @(negedge clk);
        hb_rd = 1'b0;
        d = hb_rdata;
    endtask

    task automatic set_idx(int b, logic [7:0] i);
        cyc_wr(5'(b * 8), {8'h00, i});
    endtask

    task automatic wr_dw(logic [4:0] base, logic [31:0] v);
        for (int p = 0; p < nparts(hb_wide); p++)
            cyc_wr(base + 5'(poff(p, hb_wide)), lane(v, p, hb_wide));
    endtask

    logic [15:0] rd;
    int          c0, c1;
    logic [7:0]  ix [3];
    logic [31:0] vv [3];
    logic [31:0] got [3];

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        repeat (3) @(negedge clk);
        check(hb_rdata == 16'h0 && !reg_wr && !reg_rd && !fifo_push && !fifo_pop,
              "R9 reset", {16'h0, hb_rdata}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 index registers
        hb_wide = 1'b1;
        set_idx(0, 8'h11); set_idx(1, 8'h22); set_idx(2, 8'h33);
        cyc_rd(5'd0, rd);  check(rd == 16'h0011, "R1 idx0", {16'h0, rd}, 32'h11);
        cyc_rd(5'd8, rd);  check(rd == 16'h0022, "R1 idx1", {16'h0, rd}, 32'h22);
        cyc_rd(5'd16, rd); check(rd == 16'h0033, "R1 idx2", {16'h0, rd}, 32'h33);
        cyc_rd(5'd2, rd);  check(rd == 16'h0, "R1 idx off2", {16'h0, rd}, 32'h0);

        // R2 word writes
        c0 = wr_cnt;
        cyc_wr(5'd4, 16'h5678);
        check(wr_cnt == c0, "R2 no early commit", 32'(wr_cnt), 32'(c0));
        cyc_wr(5'd6, 16'h1234);
        check(wr_cnt == c0 + 1 && mem[8'h11] == 32'h1234_5678, "R2 commit",
              mem[8'h11], 32'h1234_5678);

        // R3 byte writes
        hb_wide = 1'b0;
        c0 = wr_cnt;
        cyc_wr(5'd12, 16'h00A1); cyc_wr(5'd13, 16'h00B2); cyc_wr(5'd14, 16'h00C3);
        check(wr_cnt == c0, "R3 no early commit", 32'(wr_cnt), 32'(c0));
        cyc_wr(5'd15, 16'h00D4);
        check(wr_cnt == c0 + 1 && mem[8'h22] == 32'hD4C3_B2A1, "R3 commit",
              mem[8'h22], 32'hD4C3_B2A1);

        // R4 read latch against concurrent change through another bank (also R5)
        hb_wide = 1'b1;
        mem[8'h33] = 32'hA1B2_C3D4;
        c1 = rd_cnt;
        cyc_rd(5'd20, rd);
        check(rd == 16'hC3D4 && rd_cnt == c1 + 1, "R4 first part", {16'h0, rd}, 32'hC3D4);
        set_idx(0, 8'h33);
        wr_dw(5'd4, 32'h5566_7788);
        cyc_rd(5'd22, rd);
        check(rd == 16'hA1B2, "R4 latched part", {16'h0, rd}, 32'hA1B2);
        check(rd_cnt == c1 + 1, "R4 single fetch", 32'(rd_cnt), 32'(c1 + 1));
        check(mem[8'h33] == 32'h5566_7788, "R5 other bank write", mem[8'h33], 32'h5566_7788);
        hb_wide = 1'b0;
        mem[8'h22] = 32'h0000_9A00;
        cyc_rd(5'd12, rd); cyc_rd(5'd13, rd);
        check(rd == 16'h009A, "R4 byte lane", {16'h0, rd}, 32'h9A);

        // R6 index write discards partial access
        hb_wide = 1'b1;
        set_idx(0, 8'h40);
        cyc_wr(5'd4, 16'h1111);
        set_idx(0, 8'h41);
        c0 = wr_cnt;
        cyc_wr(5'd6, 16'h2222);
        check(wr_cnt == c0 && mem[8'h41] == 32'hDEAD_0041, "R6 dropped",
              mem[8'h41], 32'hDEAD_0041);

        // R7 out-of-order parts
        hb_wide = 1'b0;
        set_idx(1, 8'h50);
        c0 = wr_cnt;
        cyc_wr(5'd12, 16'h0001); cyc_wr(5'd14, 16'h0002);
        cyc_wr(5'd13, 16'h0003); cyc_wr(5'd15, 16'h0004);
        check(wr_cnt == c0, "R7 skip dropped", 32'(wr_cnt), 32'(c0));
        cyc_wr(5'd12, 16'h00AA); cyc_wr(5'd13, 16'h00BB);
        cyc_wr(5'd12, 16'h0011); cyc_wr(5'd13, 16'h0022);
        cyc_wr(5'd14, 16'h0033); cyc_wr(5'd15, 16'h0044);
        check(wr_cnt == c0 + 1 && mem[8'h50] == 32'h4433_2211, "R7 restart at zero",
              mem[8'h50], 32'h4433_2211);
        c1 = rd_cnt;
        cyc_rd(5'd12, rd); cyc_wr(5'd13, 16'h0077);
        cyc_rd(5'd13, rd);
        check(rd == 16'h0 && wr_cnt == c0 + 1, "R7 direction mix", {16'h0, rd}, 32'h0);

        // R8 FIFO port
        hb_wide = 1'b1;
        c0 = wr_cnt; c1 = push_cnt;
        wr_dw(5'd24, 32'hFEED_F00D);
        check(push_cnt == c1 + 1 && last_push == 32'hFEED_F00D && wr_cnt == c0,
              "R8 push", last_push, 32'hFEED_F00D);
        fifo_src = 32'hCAFE_BEEF;
        c1 = pop_cnt;
        cyc_rd(5'd24, rd);
        check(rd == 16'hBEEF, "R8 pop lane0", {16'h0, rd}, 32'hBEEF);
        fifo_src = 32'h0;
        cyc_rd(5'd26, rd);
        check(rd == 16'hCAFE && pop_cnt == c1 + 1, "R8 pop lane1", {16'h0, rd}, 32'hCAFE);

        // R10 unused region, R9 hold
        c0 = wr_cnt; c1 = rd_cnt;
        cyc_wr(5'd28, 16'hFFFF);
        check(wr_cnt == c0 && push_cnt == 1 && hb_rdata == 16'hCAFE, "R9 hold",
              {16'h0, hb_rdata}, 32'hCAFE);
        cyc_rd(5'd28, rd);
        check(rd == 16'h0 && rd_cnt == c1, "R10 unused read", {16'h0, rd}, 32'h0);

        // R5 random interleaving across banks
        for (int it = 0; it < 30; it++) begin
            hb_wide = $urandom_range(0, 1);
            for (int b = 0; b < 3; b++) begin
                ix[b] = 8'(8'h80 + it * 3 + b);
                vv[b] = $urandom;
                got[b] = '0;
                set_idx(b, ix[b]);
            end
            for (int p = 0; p < nparts(hb_wide); p++)
                for (int b = 0; b < 3; b++)
                    cyc_wr(5'(b * 8 + 4) + 5'(poff(p, hb_wide)), lane(vv[b], p, hb_wide));
            for (int p = 0; p < nparts(hb_wide); p++)
                for (int b = 0; b < 3; b++) begin
                    cyc_rd(5'(b * 8 + 4) + 5'(poff(p, hb_wide)), rd);
                    if (hb_wide) got[b][16*p +: 16] = rd;
                    else         got[b][8*p +: 8] = rd[7:0];
                end
            for (int b = 0; b < 3; b++) begin
                check(got[b] == vv[b], "R5 interleaved readback", got[b], vv[b]);
                check(mem[ix[b]] == vv[b], "R5 interleaved commit", mem[ix[b]], vv[b]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule